// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block steps through a writable control store of 256 micro-words. An 8-bit micro-address register selects the current word. The upper part of that word is presented at once on the micro-operation output. The lower nine bits decide where the sequencer goes next:
- With the select bit (bit 8) low, bits 7..0 name the successor address directly.
- With the select bit high, the successor is a dispatch address. It is formed from the 4-bit opcode input in the upper nibble, with the low nibble zero.

There is no incrementer and no test of status conditions. Every successor is either written into the micro-word or derived from the opcode.

The store has a plain write port. Writes take effect only while the sequencer is held in clear, which lets the owner load the microcode before running. An enable input gates every address transition. A synchronous clear returns the sequencer to address 0 and overrides enable.

Top module: `mseq_core`

## Requirements
- R1: A write (wr_en high at a rising edge while clear is high) stores wr_data at wr_addr. The stored word is visible on uop, during the same cycle, whenever it is the addressed word.
- R2: A write request made while clear is low is ignored, and the addressed store word keeps its previous contents.
- R3: uop equals bits WORD_W-1 down to 9 of the word at the current micro-address. With the default WORD_W of 20 this is 11 bits, and the output follows the address combinationally.
- R4: At a rising edge with enable high and clear low, if bit 8 of the current word is 0, the micro-address becomes bits 7..0 of that word. This includes wrapping from 0xFF to 0x00 when the field says so.
- R5: At a rising edge with enable high and clear low, if bit 8 of the current word is 1, the micro-address becomes {opcode, 4'b0000}. Bits 7..0 of the word are ignored in this case. This holds for all 16 opcode values.
- R6: At a rising edge with enable low and clear low, the micro-address does not change, whatever the opcode.
- R7: At a rising edge with clear high, the micro-address becomes 0, even when enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous return to micro-address 0; also opens the store write port |
| enable | input | 1 | Allows the micro-address to advance |
| opcode | input | 4 | Dispatch source for mapped successors |
| wr_en | input | 1 | Store write request |
| wr_addr | input | 8 | Store write address |
| wr_data | input | WORD_W | Store write word |
| uop | output | WORD_W-9 | Micro-operation field of the current word |

## Verification
Three results are due at different times:
- A successor address is due one rising edge after its inputs are applied. Its uop is then due combinationally, so the bench drives every input at a falling edge and samples uop at the next falling edge, half a cycle after the edge that moved the address.
- A store write becomes visible on the same falling-edge sample that follows the writing edge, because the read is combinational.
- A clear lands on the first edge it is high for.

Each test word carries its own address in the low 8 bits of its micro-operation field. A single uop sample therefore shows both where the sequencer went and that the field was extracted correctly, and the bench compares it against its own model of the successor rule.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  // which rule produced the successor address
  typedef enum logic {
    SRC_LINK = 1'b0,
    SRC_MAP  = 1'b1
  } next_src_e;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_data;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4
) (
  input  logic [ADDR_W:0]   link_field,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] nxt_addr,
  output next_src_e         nxt_src
);
  localparam int PAD_W = ADDR_W - OPC_W;

  function automatic logic [ADDR_W-1:0] dispatch_addr(input logic [OPC_W-1:0] opc);
    return {opc, {PAD_W{1'b0}}};
  endfunction

  function automatic next_src_e pick_src(input logic sel);
    return sel ? SRC_MAP : SRC_LINK;
  endfunction

  always_comb begin
    nxt_src = pick_src(link_field[ADDR_W]);
    if (nxt_src == SRC_MAP) nxt_addr = dispatch_addr(opcode);
    else                    nxt_addr = link_field[ADDR_W-1:0];
  end
endmodule

// File: rtl/mseq_areg.sv
module mseq_areg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              enable,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              primed
);
  logic primed_q = 1'b0;

  always_ff @(posedge clk) begin
    if (clear)       cur_addr <= '0;
    else if (enable) cur_addr <= nxt_addr;
  end

  always_ff @(posedge clk) primed_q <= primed_q | clear;
  assign primed = primed_q;

  assert_clear_zero_R7: assert property (@(posedge clk)
    clear |=> (cur_addr == '0));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!primed_q)
    (!clear && !enable) |=> $stable(cur_addr));
endmodule

// File: rtl/mseq_core.sv
module mseq_core
  import mseq_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4
) (
  input  logic                     clk,
  input  logic                     clear,
  input  logic                     enable,
  input  logic [OPC_W-1:0]         opcode,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [WORD_W-ADDR_W-2:0] uop
);
  localparam int UOP_W = WORD_W - ADDR_W - 1;
  localparam int PAD_W = ADDR_W - OPC_W;

  logic [WORD_W-1:0] cur_word;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  next_src_e         nxt_src;
  logic              primed;
  logic              load_fire;
  logic              step_fire;

  function automatic logic [UOP_W-1:0] uop_field(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W+1];
  endfunction

  assign load_fire = wr_en & clear;
  assign step_fire = enable & ~clear;

  mseq_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .load_en(load_fire), .load_addr(wr_addr), .load_data(wr_data),
    .rd_addr(cur_addr), .rd_word(cur_word)
  );

  mseq_next #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_next (
    .link_field(cur_word[ADDR_W:0]), .opcode(opcode),
    .nxt_addr(nxt_addr), .nxt_src(nxt_src)
  );

  mseq_areg #(.ADDR_W(ADDR_W)) u_areg (
    .clk(clk), .clear(clear), .enable(enable), .nxt_addr(nxt_addr),
    .cur_addr(cur_addr), .primed(primed)
  );

  assign uop = uop_field(cur_word);

  assert_link_follow_R4: assert property (@(posedge clk) disable iff (!primed)
    (step_fire && !cur_word[ADDR_W]) |=> (cur_addr == $past(cur_word[ADDR_W-1:0])));

  assert_map_dispatch_R5: assert property (@(posedge clk) disable iff (!primed)
    (step_fire && cur_word[ADDR_W]) |=> (cur_addr == {$past(opcode), {PAD_W{1'b0}}}));

  assert_load_visible_R1: assert property (@(posedge clk) disable iff (!primed)
    (load_fire && wr_addr == '0) |=> (cur_word == $past(wr_data)));
endmodule

// File: tb/mseq_core_tb.sv
`timescale 1ns/1ps
module mseq_core_tb;
  logic        clk = 1'b0;
  logic        clear = 1'b1;
  logic        enable = 1'b0;
  logic [3:0]  opcode = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;
  logic [10:0] uop;

  int total = 0;
  int bad = 0;
  logic [19:0] tbl [256];
  logic [7:0]  exp_addr = '0;

  always #4 clk = ~clk;

  mseq_core u_dut (
    .clk(clk), .clear(clear), .enable(enable), .opcode(opcode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .uop(uop)
  );

  function automatic logic [19:0] mk_word(input int a);
    logic [7:0] av;
    logic       sel;
    logic [7:0] lnk;
    av  = 8'(a);
    sel = (av[3:0] == 4'h1) && !av[4];
    lnk = sel ? ~av : av + 8'd1;
    return {av[2:0] ^ 3'b101, av, sel, lnk};
  endfunction

  function automatic logic [7:0] model_next(input logic [19:0] w, input logic [3:0] op);
    if (w[8]) return {op, 4'h0};
    return w[7:0];
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    total++;
    if (uop !== exp) begin
      bad++;
      $display("FAIL %s uop actual=%h expected=%h", req, uop, exp);
    end
  endtask

  task automatic do_clear(input string req);
    @(negedge clk); clear = 1'b1; enable = 1'b1; opcode = 4'hA;
    @(negedge clk); clear = 1'b0; enable = 1'b0;
    exp_addr = '0;
    check(req, tbl[0][19:9]);
  endtask

  task automatic step(input logic [3:0] op, input logic en, input string req);
    @(negedge clk); opcode = op; enable = en;
    if (en) exp_addr = model_next(tbl[exp_addr], op);
    @(negedge clk); enable = 1'b0;
    check(req, tbl[exp_addr][19:9]);
  endtask

  task automatic t_load;
    clear = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 8'(a); wr_data = mk_word(a); tbl[a] = mk_word(a);
    end
    @(negedge clk); wr_en = 1'b0; clear = 1'b0;
    check("R1 load+R3 field at addr0", tbl[0][19:9]);
  endtask

  task automatic t_link_chain;
    do_clear("R7 clear");
    step(4'h0, 1'b1, "R4 link 0->1");
    step(4'hF, 1'b1, "R5 dispatch to F0");
    for (int k = 0; k < 16; k++) step(4'h3, 1'b1, "R4 link chain F0..FF wrap");
    check("R4 wrap to 00", tbl[8'h00][19:9]);
  endtask

  task automatic t_dispatch_all;
    for (int op = 0; op < 16; op++) begin
      do_clear("R7 clear before dispatch");
      step(4'h0, 1'b1, "R4 link to 01");
      step(4'(op), 1'b1, "R5 dispatch opcode");
      check("R5 dispatch addr in uop", {(3'(op << 4)) ^ 3'b101, 8'(op << 4)});
    end
  endtask

  task automatic t_hold;
    do_clear("R7 clear");
    step(4'h0, 1'b1, "R4 link to 01");
    for (int k = 0; k < 4; k++) step(4'(k * 5 + 2), 1'b0, "R6 hold while idle");
    step(4'h6, 1'b1, "R5 dispatch after hold");
  endtask

  task automatic t_clear_priority;
    do_clear("R7 clear");
    step(4'h0, 1'b1, "R4 link to 01");
    step(4'h9, 1'b1, "R5 dispatch to 90");
    @(negedge clk); clear = 1'b1; enable = 1'b1; opcode = 4'h7;
    @(negedge clk);
    exp_addr = '0;
    check("R7 clear beats enable", tbl[0][19:9]);
    clear = 1'b0; enable = 1'b0;
  endtask

  task automatic t_write_ignored;
    do_clear("R7 clear");
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h13; wr_data = '1;
    @(negedge clk); wr_en = 1'b0;
    step(4'h0, 1'b1, "R4 link to 01");
    step(4'h1, 1'b1, "R5 dispatch to 10");
    step(4'h0, 1'b1, "R4 link to 11");
    step(4'h0, 1'b1, "R4 link to 12");
    step(4'h0, 1'b1, "R2 word 13 unchanged");
    check("R2 addr 13 holds original", mk_word(8'h13) >> 9);
  endtask

  task automatic t_rewrite;
    @(negedge clk); clear = 1'b1; wr_en = 1'b1; wr_addr = 8'h00;
    wr_data = {11'h5A5, 1'b0, 8'h01};
    tbl[0] = wr_data;
    @(negedge clk); wr_en = 1'b0;
    check("R1 rewrite visible same cycle", 11'h5A5);
    clear = 1'b0;
    exp_addr = '0;
    step(4'h0, 1'b1, "R4 rewritten link to 01");
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_load();
    t_link_chain();
    t_dispatch_all();
    t_hold();
    t_clear_priority();
    t_write_ignored();
    t_rewrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule